// File: doc/BRIEF.md
# CAN Node Fault Confinement and Bus-Off Recovery

This block holds the transmit and receive error counters of a CAN node and derives two status flags from them: a warning flag, raised while either counter sits at or above the warning limit, and a bus-off flag. The protocol engine drives per-event strobes. An increment strobe carries a step size, and a decrement strobe lowers a counter by one. The rules that decide which event moves which counter by how much stay in the engine.

When a transmit-side update would carry the transmit counter past the bus-off limit, the node goes bus-off. The block then forces its reset-request bit to 1 and freezes both counters. The host has to write reset-request back to 0. Only then does the block count bus-free pulses from the engine. On the 128th pulse it clears both counters and both flags, and the node is active again.

The error interrupt is a single-cycle pulse. It fires when the warning flag or the bus-off flag changes, but only while the host's enable input is high.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, and `err_status`, `bus_off`, `reset_req` and `err_irq` are all 0.
- R2: An increment strobe adds its step to its counter, saturating at 511. A decrement strobe subtracts 1 and stays at 0 when the counter is already 0. When both strobes arrive in the same cycle, the increment wins. Every update is visible one clock after the strobe.
- R3: `err_status` is 1 exactly when the transmit counter or the receive counter is 96 or above.
- R4: In the clock where the transmit counter's new value would exceed 255, `bus_off` and `reset_req` both become 1 along with that counter value.
- R5: While `bus_off` is 1, increment and decrement strobes leave both counters unchanged.
- R6: A host write (`host_wr_en`=1) loads `host_rr_val` into `reset_req`. While the node is bus-off, `reset_req` stays 1 until the host writes 0.
- R7: Bus-free pulses that arrive before the host clears `reset_req` are not counted. After the clear, the clock of the 128th pulse sets `bus_off`, `err_status` and both counters to 0.
- R8: A host write of 1 during the bus-free wait stops the wait and restarts it from zero at the next clear.
- R9: `err_irq` is 1 for exactly the cycles in which `err_status` or `bus_off` differs from its value in the previous cycle, and only when `irq_en` is 1.
- R10: The receive counter never causes bus-off, even at its saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_inc | input | 1 | Transmit counter increment strobe |
| tx_inc_amt | input | 4 | Step added by `tx_inc` |
| tx_dec | input | 1 | Transmit counter decrement strobe |
| rx_inc | input | 1 | Receive counter increment strobe |
| rx_inc_amt | input | 4 | Step added by `rx_inc` |
| rx_dec | input | 1 | Receive counter decrement strobe |
| bus_free | input | 1 | One-cycle pulse for each detected bus-free occurrence |
| host_wr_en | input | 1 | Host write strobe for the reset-request bit |
| host_rr_val | input | 1 | Value written to the reset-request bit |
| irq_en | input | 1 | Error interrupt enable |
| tx_cnt | output | 9 | Transmit error counter |
| rx_cnt | output | 9 | Receive error counter |
| err_status | output | 1 | Warning flag: a counter is at or above 96 |
| bus_off | output | 1 | Node is bus-off |
| reset_req | output | 1 | Reset-request state |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The counters are driven with single steps, with large steps up to saturation, with an increment and a decrement in the same cycle, and with a decrement at zero. These patterns separate a correct saturating counter from one that wraps or underflows. Both counters are walked across the warning limit with the interrupt enable high and then low, so a change of the warning flag is seen with and without an interrupt pulse. The bus-off sequence sends bus-free pulses before the host clear, aborts a partial wait with a host write of 1, and then stops at the 127th pulse and again at the 128th. These cases separate counting that starts too early, a recovery count that is kept across an abort, and an off-by-one in the recovery count.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HOLD   = 2'd1,
    ST_WAIT   = 2'd2
  } rec_state_e;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int N_CH  = 2;

endpackage

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt #(
  parameter int CNT_W      = 9,
  parameter int AMT_W      = 4,
  parameter int WARN_LIM   = 96,
  parameter int BUSOFF_LIM = 255,
  parameter bit CAN_TRIP   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [AMT_W-1:0] amt,
  input  logic             dec,
  input  logic             freeze,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             warn,
  output logic             trip
);

  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(BUSOFF_LIM);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign sum = {1'b0, cnt_q} + {{(CNT_W + 1 - AMT_W){1'b0}}, amt};

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr) begin
      cnt_nxt = '0;
    end else if (!freeze) begin
      if (inc) begin
        cnt_nxt = sum[CNT_W] ? MAX_V : sum[CNT_W-1:0];
      end else if (dec && (cnt_q != '0)) begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = clr | (!freeze & (inc | dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign warn = (cnt_q >= WARN_V);

  generate
    if (CAN_TRIP) begin : g_trip
      assign trip = !freeze && (cnt_nxt > LIM_V);
    end else begin : g_notrip
      assign trip = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery
  import can_fc_pkg::*;
#(
  parameter int RECOV_CNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic bus_free,
  input  logic host_wr_en,
  input  logic host_rr_val,
  output logic bus_off,
  output logic reset_req,
  output logic recov_clr
);

  localparam int WC_W = (RECOV_CNT > 1) ? $clog2(RECOV_CNT) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(RECOV_CNT - 1);

  rec_state_e      st_q, st_nxt;
  logic            rr_q, rr_nxt;
  logic [WC_W-1:0] wc_q, wc_nxt;

  always_comb begin
    st_nxt    = st_q;
    rr_nxt    = rr_q;
    wc_nxt    = wc_q;
    recov_clr = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (trip) begin
          st_nxt = ST_HOLD;
          rr_nxt = 1'b1;
        end else if (host_wr_en) begin
          rr_nxt = host_rr_val;
        end
      end
      ST_HOLD: begin
        if (host_wr_en) begin
          rr_nxt = host_rr_val;
          if (!host_rr_val) begin
            st_nxt = ST_WAIT;
            wc_nxt = '0;
          end
        end
      end
      ST_WAIT: begin
        if (host_wr_en && host_rr_val) begin
          st_nxt = ST_HOLD;
          rr_nxt = 1'b1;
        end else if (bus_free) begin
          if (wc_q == WC_LAST) begin
            st_nxt    = ST_ACTIVE;
            wc_nxt    = '0;
            recov_clr = 1'b1;
          end else begin
            wc_nxt = wc_q + 1'b1;
          end
        end
      end
      default: begin
        st_nxt = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ACTIVE;
      rr_q <= 1'b0;
      wc_q <= '0;
    end else begin
      st_q <= st_nxt;
      rr_q <= rr_nxt;
      wc_q <= wc_nxt;
    end
  end

  assign bus_off   = (st_q != ST_ACTIVE);
  assign reset_req = rr_q;

endmodule

// File: rtl/can_fc_irq.sv
module can_fc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic err_status,
  input  logic bus_off,
  output logic err_irq
);

  logic err_prev_q, boff_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_prev_q  <= 1'b0;
      boff_prev_q <= 1'b0;
    end else begin
      err_prev_q  <= err_status;
      boff_prev_q <= bus_off;
    end
  end

  assign err_irq = irq_en & ((err_status ^ err_prev_q) | (bus_off ^ boff_prev_q));

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int AMT_W      = 4,
  parameter int WARN_LIM   = 96,
  parameter int BUSOFF_LIM = 255,
  parameter int RECOV_CNT  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_inc,
  input  logic [AMT_W-1:0] tx_inc_amt,
  input  logic             tx_dec,
  input  logic             rx_inc,
  input  logic [AMT_W-1:0] rx_inc_amt,
  input  logic             rx_dec,
  input  logic             bus_free,
  input  logic             host_wr_en,
  input  logic             host_rr_val,
  input  logic             irq_en,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [CNT_W-1:0] rx_cnt,
  output logic             err_status,
  output logic             bus_off,
  output logic             reset_req,
  output logic             err_irq
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  logic [N_CH-1:0]            inc_v, dec_v, warn_v, trip_v;
  logic [N_CH-1:0][AMT_W-1:0] amt_v;
  logic [N_CH-1:0][CNT_W-1:0] cnt_v;
  logic                       recov_clr, trip_any;

  assign inc_v[CH_TX] = tx_inc;
  assign inc_v[CH_RX] = rx_inc;
  assign dec_v[CH_TX] = tx_dec;
  assign dec_v[CH_RX] = rx_dec;
  assign amt_v[CH_TX] = tx_inc_amt;
  assign amt_v[CH_RX] = rx_inc_amt;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_cnt
      can_fc_errcnt #(
        .CNT_W     (CNT_W),
        .AMT_W     (AMT_W),
        .WARN_LIM  (WARN_LIM),
        .BUSOFF_LIM(BUSOFF_LIM),
        .CAN_TRIP  (i == CH_TX)
      ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n_i),
        .inc   (inc_v[i]),
        .amt   (amt_v[i]),
        .dec   (dec_v[i]),
        .freeze(bus_off),
        .clr   (recov_clr),
        .cnt_q (cnt_v[i]),
        .warn  (warn_v[i]),
        .trip  (trip_v[i])
      );
    end
  endgenerate

  assign trip_any = |trip_v;

  can_fc_recovery #(
    .RECOV_CNT(RECOV_CNT)
  ) u_rec (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .trip       (trip_any),
    .bus_free   (bus_free),
    .host_wr_en (host_wr_en),
    .host_rr_val(host_rr_val),
    .bus_off    (bus_off),
    .reset_req  (reset_req),
    .recov_clr  (recov_clr)
  );

  assign err_status = |warn_v;
  assign tx_cnt     = cnt_v[CH_TX];
  assign rx_cnt     = cnt_v[CH_RX];

  can_fc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .irq_en    (irq_en),
    .err_status(err_status),
    .bus_off   (bus_off),
    .err_irq   (err_irq)
  );

endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int CNT_W      = 9,
  parameter int BUSOFF_LIM = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             err_status,
  input logic             bus_off,
  input logic             reset_req,
  input logic             host_wr_en,
  input logic             err_irq
);

  p_rr_on_busoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> reset_req);

  p_only_tx_trips_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> (tx_cnt > CNT_W'(BUSOFF_LIM)));

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && $past(bus_off)) |-> ($stable(tx_cnt) && $stable(rx_cnt)));

  p_rr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && reset_req && !host_wr_en) |=> reset_req);

  p_recover_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> (tx_cnt == '0 && rx_cnt == '0 && !err_status));

  p_irq_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (!$stable(err_status) || !$stable(bus_off)));

endmodule

bind can_fault_confine can_fc_chk #(
  .CNT_W     (CNT_W),
  .BUSOFF_LIM(BUSOFF_LIM)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .err_status(err_status),
  .bus_off   (bus_off),
  .reset_req (reset_req),
  .host_wr_en(host_wr_en),
  .err_irq   (err_irq)
);

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0;
  logic [3:0] tx_amt = 0, rx_amt = 0;
  logic       bus_free = 0, host_wr_en = 0, host_rr_val = 0, irq_en = 0;
  logic [8:0] tx_cnt, rx_cnt;
  logic       err_status, bus_off, reset_req, err_irq;

  always #10 clk = ~clk;

  can_fault_confine dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_inc(tx_inc), .tx_inc_amt(tx_amt), .tx_dec(tx_dec),
    .rx_inc(rx_inc), .rx_inc_amt(rx_amt), .rx_dec(rx_dec),
    .bus_free(bus_free), .host_wr_en(host_wr_en), .host_rr_val(host_rr_val),
    .irq_en(irq_en),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .err_status(err_status),
    .bus_off(bus_off), .reset_req(reset_req), .err_irq(err_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference model
  int m_tx, m_rx, m_st, m_rr, m_wc, m_errp, m_bop;

  function automatic int upd(int c, bit inc, int amt, bit dec, bit frz);
    if (frz) return c;
    if (inc) return (c + amt > 511) ? 511 : c + amt;
    if (dec && c > 0) return c - 1;
    return c;
  endfunction

  function automatic int m_err();
    return (m_tx >= 96 || m_rx >= 96) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_st = 0; m_rr = 0; m_wc = 0; m_errp = 0; m_bop = 0;
    end else begin
      int bo, ntx, nrx, nst, nrr, nwc;
      bo  = (m_st != 0);
      ntx = upd(m_tx, tx_inc, tx_amt, tx_dec, bo != 0);
      nrx = upd(m_rx, rx_inc, rx_amt, rx_dec, bo != 0);
      nst = m_st; nrr = m_rr; nwc = m_wc;
      if (m_st == 0) begin
        if (ntx > 255) begin nst = 1; nrr = 1; end
        else if (host_wr_en) nrr = host_rr_val;
      end else if (m_st == 1) begin
        if (host_wr_en) begin
          nrr = host_rr_val;
          if (!host_rr_val) begin nst = 2; nwc = 0; end
        end
      end else begin
        if (host_wr_en && host_rr_val) begin nst = 1; nrr = 1; end
        else if (bus_free) begin
          if (m_wc == 127) begin nst = 0; nwc = 0; ntx = 0; nrx = 0; end
          else nwc = m_wc + 1;
        end
      end
      m_errp = m_err(); m_bop = bo;
      m_tx = ntx; m_rx = nrx; m_st = nst; m_rr = nrr; m_wc = nwc;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  task automatic cyc();
    int bo, irq;
    @(negedge clk);
    bo  = (m_st != 0);
    irq = irq_en && ((m_err() != m_errp) || (bo != m_bop));
    chk("R2 tx_cnt", tx_cnt, m_tx);
    chk("R2 rx_cnt", rx_cnt, m_rx);
    chk("R3 err_status", err_status, m_err());
    chk("R4 bus_off", bus_off, bo);
    chk("R6 reset_req", reset_req, m_rr);
    chk("R9 err_irq", err_irq, irq);
  endtask

  task automatic tx_pulse(int amt);
    tx_inc = 1; tx_amt = amt[3:0]; cyc(); tx_inc = 0; tx_amt = 0;
  endtask
  task automatic rx_pulse(int amt);
    rx_inc = 1; rx_amt = amt[3:0]; cyc(); rx_inc = 0; rx_amt = 0;
  endtask
  task automatic rx_down();
    rx_dec = 1; cyc(); rx_dec = 0;
  endtask
  task automatic host_wr(bit v);
    host_wr_en = 1; host_rr_val = v; cyc(); host_wr_en = 0; host_rr_val = 0;
  endtask
  task automatic free_pulses(int n);
    for (int i = 0; i < n; i++) begin bus_free = 1; cyc(); bus_free = 0; cyc(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tx_cnt", tx_cnt, 0);
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 flags", {err_status, bus_off, reset_req, err_irq}, 0);
    rst_n = 1;
    repeat (4) cyc();
    chk("R1 idle after release", {err_status, bus_off, reset_req}, 0);

    // R2: steps, simultaneous inc/dec, decrement at zero
    rx_down();
    chk("R2 dec at zero", rx_cnt, 0);
    rx_pulse(1); rx_pulse(3);
    chk("R2 steps", rx_cnt, 4);
    rx_inc = 1; rx_amt = 2; rx_dec = 1; cyc(); rx_inc = 0; rx_amt = 0; rx_dec = 0;
    chk("R2 inc wins", rx_cnt, 6);
    rx_down();
    chk("R2 dec by one", rx_cnt, 5);

    // R3/R9: cross the warning limit with irq enabled, then disabled
    irq_en = 1;
    for (int i = 0; i < 11; i++) rx_pulse(8);
    rx_pulse(2);
    chk("R3 at 95", {31'd0, err_status}, 0);
    rx_inc = 1; rx_amt = 1; cyc(); rx_inc = 0; rx_amt = 0;
    chk("R3 at 96", err_status, 1);
    chk("R9 pulse on rise", err_irq, 1);
    cyc();
    chk("R9 one cycle", err_irq, 0);
    irq_en = 0;
    rx_down();
    chk("R3 back under", err_status, 0);
    chk("R9 gated off", err_irq, 0);
    irq_en = 1;

    // R10: receive counter saturates without bus-off
    for (int i = 0; i < 40; i++) rx_pulse(15);
    chk("R2 saturate", rx_cnt, 511);
    chk("R10 no bus-off from rx", bus_off, 0);
    rx_pulse(15);
    chk("R2 stays saturated", rx_cnt, 511);

    // R6: host writes while active
    host_wr(1);
    chk("R6 write 1", reset_req, 1);
    host_wr(0);
    chk("R6 write 0", reset_req, 0);

    // R4: transmit counter over the limit
    for (int i = 0; i < 31; i++) tx_pulse(8);
    chk("R4 at 248", bus_off, 0);
    tx_pulse(8);
    chk("R4 bus_off", bus_off, 1);
    chk("R4 reset_req", reset_req, 1);
    chk("R4 tx value", tx_cnt, 256);

    // R5: strobes ignored while bus-off
    tx_pulse(5); rx_down();
    tx_dec = 1; cyc(); tx_dec = 0;
    chk("R5 tx held", tx_cnt, 256);
    chk("R5 rx held", rx_cnt, 511);

    // R7: early bus-free pulses ignored
    free_pulses(130);
    chk("R7 early pulses", bus_off, 1);
    chk("R6 still requested", reset_req, 1);

    // R8: abort a partial wait
    host_wr(0);
    free_pulses(60);
    host_wr(1);
    chk("R8 back to hold", reset_req, 1);
    host_wr(0);
    free_pulses(127);
    chk("R8 restarted count", bus_off, 1);
    bus_free = 1; cyc(); bus_free = 0;
    chk("R7 recovered", bus_off, 0);
    chk("R7 tx cleared", tx_cnt, 0);
    chk("R7 rx cleared", rx_cnt, 0);
    chk("R7 err cleared", err_status, 0);
    chk("R9 recovery irq", err_irq, 1);
    cyc();
    chk("R9 irq dropped", err_irq, 0);
    tx_pulse(3);
    chk("R5 counting resumes", tx_cnt, 3);
    repeat (3) cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule